// File: doc/BRIEF.md
# Attribute-Keyed Page Translation Cache

This block caches translations from linear page numbers to physical frame numbers. Each entry stores a 20-bit linear page and a 20-bit frame, plus four attribute bits: valid, dirty, writable and user. The attributes form part of the match key; they are not carried in the data. A requester presents a linear address, a privilege flag and a read/write flag. The lookup result is a registered hit flag and frame, which appear one cycle after the request.

A page walker outside the block installs translations through the fill port after it has checked protection and updated accessed and dirty flags in memory. Linear address bits 29:28 select one of four sets of eight ways. A write succeeds only against an entry that is already writable and dirty. Any other write misses, which makes the walker mark the page dirty and refill the entry. When a refill differs from an existing entry only in its dirty bit, it overwrites that entry in place instead of taking another way. A flush input drops every translation at once.

Top module: `xlat_cache`

## Requirements
- R1: A read lookup hits when a valid entry in the selected set has the same 20-bit page (address bits 31:12) and the same user flag, whatever its dirty and writable bits. The hit flag and frame are registered and appear on the cycle after the request.
- R2: An entry installed with one user flag never hits a lookup made with the other user flag.
- R3: A write lookup hits only on an entry with writable=1 and dirty=1. A clean entry or a read-only entry gives a miss.
- R4: A fill whose page, user flag and writable flag equal those of a valid entry in its set overwrites only that entry's dirty bit and frame. It allocates no way and does not move the replacement order.
- R5: Any other fill goes to the set chosen by address bits 29:28 and takes the lowest-numbered way that is not valid. The new entry is written with valid=1.
- R6: When all ways of the set are valid, a new fill replaces the oldest allocated entry. A per-set FIFO pointer advances by one on each allocation and wraps after the last way.
- R7: When a fill and a lookup fall in the same cycle, the lookup sees the contents as they are after the fill.
- R8: Flush invalidates every entry in a single cycle. A lookup in the same cycle misses, a fill in the same cycle is dropped, and replacement in every set starts again at way 0.
- R9: The cycle after a cycle with no lookup request, and the cycle after a miss, show hit=0 and frame=0.
- R10: When more than one entry matches a lookup, the frame comes from the lowest-numbered matching way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_lin | input | 32 | Lookup linear address |
| lk_user | input | 1 | Requester at user privilege |
| lk_write | input | 1 | Lookup is for a write |
| lk_hit | output | 1 | Registered hit |
| lk_frame | output | 20 | Registered physical frame, zero on miss |
| fl_req | input | 1 | Fill request from the page walker |
| fl_lin | input | 32 | Fill linear address |
| fl_user | input | 1 | Fill user flag |
| fl_writable | input | 1 | Fill writable flag |
| fl_dirty | input | 1 | Fill dirty flag |
| fl_frame | input | 20 | Fill physical frame |

## Verification
The assertions assume that every input is a defined level at each rising edge and that the page walker gives a fill at most one cycle. They also assume the replacement pointer stays in step with allocation, which holds because valid bits are cleared only by flush. Nothing in the assertions requires fill and lookup to be kept apart: the bench drives both in the same cycle, often to the same set. The stimulus draws pages from a small pool in each set so that hits, in-place dirty updates and evictions all happen often. Rare flushes are mixed in, and directed sequences fill a set past its capacity.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned PAGE_W  = 20;
  localparam int unsigned FRAME_W = 20;
  localparam int unsigned OFS_W   = 12;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              valid;
    logic              dirty;
    logic              writable;
    logic              user;
  } xtag_t;

  typedef logic [FRAME_W-1:0] xframe_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int unsigned SETS = 4,
  parameter int unsigned WAYS = 8,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned ENT   = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAYS-1:0]  wr_oh,
  input  xtag_t            wr_tag,
  input  xframe_t          wr_frame,
  output xtag_t            tag_q   [ENT],
  output xtag_t            tag_nx  [ENT],
  output xframe_t          frame_nx[ENT]
);

  xtag_t          body_q [ENT];
  xframe_t        frame_q[ENT];
  logic [ENT-1:0] valid_q, valid_nx, we;

  // write enables, one per entry
  always_comb begin
    for (int s = 0; s < int'(SETS); s++) begin
      for (int w = 0; w < int'(WAYS); w++) begin
        we[s*WAYS + w] = wr_en && !flush && (wr_set == SET_W'(s)) && wr_oh[w];
      end
    end
  end

  // next-state view, also consumed by the lookup path
  always_comb begin
    for (int e = 0; e < int'(ENT); e++) begin
      valid_nx[e] = flush ? 1'b0 : (we[e] ? 1'b1 : valid_q[e]);
      tag_nx[e]   = we[e] ? wr_tag : body_q[e];
      tag_nx[e].valid = valid_nx[e];
      frame_nx[e] = we[e] ? wr_frame : frame_q[e];
      tag_q[e]    = body_q[e];
      tag_q[e].valid = valid_q[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_nx;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < int'(ENT); e++) begin
      if (we[e]) begin
        body_q[e]  <= wr_tag;
        frame_q[e] <= wr_frame;
      end
    end
  end

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int unsigned WAYS      = 8,
  parameter bit          FILL_MODE = 1'b0
) (
  input  xtag_t             row[WAYS],
  input  logic [PAGE_W-1:0] page,
  input  logic              user,
  input  logic              attr,
  output logic [WAYS-1:0]   hit
);
  // FILL_MODE: attr is the writable flag, compared exactly, dirty ignored.
  // lookup mode: attr is the write flag, requiring writable and dirty.
  for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
    if (FILL_MODE) begin : g_fill
      assign hit[w] = row[w].valid && (row[w].page == page) &&
                      (row[w].user == user) && (row[w].writable == attr);
    end else begin : g_look
      assign hit[w] = row[w].valid && (row[w].page == page) &&
                      (row[w].user == user) &&
                      (!attr || (row[w].writable && row[w].dirty));
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned SETS = 4,
  parameter int unsigned WAYS = 8,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic             upd,
  input  logic [SET_W-1:0] set,
  input  logic [WAYS-1:0]  valid_row,
  output logic [WAYS-1:0]  alloc_oh
);
  logic [SETS-1:0][WAY_W-1:0] ptr_q, ptr_nx;
  logic [WAYS-1:0]            free_oh;
  logic                       any_free, alloc;

  always_comb begin
    free_oh  = '0;
    any_free = 1'b0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (!valid_row[w] && !any_free) begin
        free_oh[w] = 1'b1;
        any_free   = 1'b1;
      end
    end
    alloc_oh = any_free ? free_oh : (WAYS'(1) << ptr_q[set]);
  end

  assign alloc = fill_en && !upd && !flush;

  always_comb begin
    ptr_nx = ptr_q;
    if (flush) begin
      ptr_nx = '0;
    end else if (alloc) begin
      ptr_nx[set] = (ptr_q[set] == WAY_W'(WAYS-1)) ? '0 : ptr_q[set] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nx;
  end

  assert_update_keeps_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && upd && !flush) |=> $stable(ptr_q));

  assert_flush_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ptr_q == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned SETS    = 4,
  parameter int unsigned WAYS    = 8,
  parameter int unsigned SET_LSB = 28,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned ENT    = SETS * WAYS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         lk_req,
  input  logic [31:0]  lk_lin,
  input  logic         lk_user,
  input  logic         lk_write,
  output logic         lk_hit,
  output logic [19:0]  lk_frame,
  input  logic         fl_req,
  input  logic [31:0]  fl_lin,
  input  logic         fl_user,
  input  logic         fl_writable,
  input  logic         fl_dirty,
  input  logic [19:0]  fl_frame
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic [SET_W-1:0]  fl_set, lk_set;
  logic [PAGE_W-1:0] fl_page, lk_page;
  assign fl_set  = fl_lin[SET_LSB +: SET_W];
  assign lk_set  = lk_lin[SET_LSB +: SET_W];
  assign fl_page = fl_lin[31 -: PAGE_W];
  assign lk_page = lk_lin[31 -: PAGE_W];

  xtag_t   tag_q   [ENT];
  xtag_t   tag_nx  [ENT];
  xframe_t frame_nx[ENT];
  xtag_t   fl_row  [WAYS];
  xtag_t   lk_row  [WAYS];
  logic [WAYS-1:0] fl_valid_row;

  always_comb begin
    for (int w = 0; w < int'(WAYS); w++) begin
      fl_row[w]       = tag_q [int'(fl_set)*WAYS + w];
      lk_row[w]       = tag_nx[int'(lk_set)*WAYS + w];
      fl_valid_row[w] = fl_row[w].valid;
    end
  end

  // fill path
  logic [WAYS-1:0] fl_match, upd_oh, alloc_oh, wr_oh;
  logic            upd;
  xtag_t           wr_tag;

  xlat_match #(.WAYS(WAYS), .FILL_MODE(1'b1)) u_fill_match (
    .row(fl_row), .page(fl_page), .user(fl_user), .attr(fl_writable), .hit(fl_match)
  );

  always_comb begin
    upd_oh = '0;
    upd    = 1'b0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (fl_match[w] && !upd) begin
        upd_oh[w] = 1'b1;
        upd       = 1'b1;
      end
    end
  end

  xlat_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_s), .flush(flush), .fill_en(fl_req), .upd(upd),
    .set(fl_set), .valid_row(fl_valid_row), .alloc_oh(alloc_oh)
  );

  assign wr_oh = upd ? upd_oh : alloc_oh;

  always_comb begin
    wr_tag.page     = fl_page;
    wr_tag.valid    = 1'b1;
    wr_tag.dirty    = fl_dirty;
    wr_tag.writable = fl_writable;
    wr_tag.user     = fl_user;
  end

  xlat_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_s), .flush(flush), .wr_en(fl_req), .wr_set(fl_set),
    .wr_oh(wr_oh), .wr_tag(wr_tag), .wr_frame(fl_frame),
    .tag_q(tag_q), .tag_nx(tag_nx), .frame_nx(frame_nx)
  );

  // lookup path, against post-fill contents
  logic [WAYS-1:0] lk_match, lk_wd;
  logic            lk_any;
  xframe_t         lk_sel_frame;

  xlat_match #(.WAYS(WAYS), .FILL_MODE(1'b0)) u_look_match (
    .row(lk_row), .page(lk_page), .user(lk_user), .attr(lk_write), .hit(lk_match)
  );

  always_comb begin
    lk_any       = 1'b0;
    lk_sel_frame = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      lk_wd[w] = lk_row[w].writable && lk_row[w].dirty;
      if (lk_match[w] && !lk_any) begin
        lk_any       = 1'b1;
        lk_sel_frame = frame_nx[int'(lk_set)*WAYS + w];
      end
    end
  end

  logic    hit_nx, hit_q;
  xframe_t frame_nx_o, frame_q;
  assign hit_nx     = lk_req && lk_any;
  assign frame_nx_o = hit_nx ? lk_sel_frame : '0;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      hit_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      hit_q   <= hit_nx;
      frame_q <= frame_nx_o;
    end
  end

  assign lk_hit   = hit_q;
  assign lk_frame = frame_q;

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !lk_req |=> (!lk_hit && lk_frame == '0));

  assert_flush_miss_R8: assert property (@(posedge clk) disable iff (!rst_s)
    flush |=> !lk_hit);

  assert_write_needs_wd_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (lk_req && lk_write) |-> ((lk_match & ~lk_wd) == '0));

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int SETS = 4;
  localparam int WAYS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_req = 1'b0, lk_user = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_lin = '0;
  logic        lk_hit;
  logic [19:0] lk_frame;
  logic        fl_req = 1'b0, fl_user = 1'b0, fl_writable = 1'b0, fl_dirty = 1'b0;
  logic [31:0] fl_lin = '0;
  logic [19:0] fl_frame = '0;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_req(lk_req), .lk_lin(lk_lin), .lk_user(lk_user), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_frame(lk_frame),
    .fl_req(fl_req), .fl_lin(fl_lin), .fl_user(fl_user),
    .fl_writable(fl_writable), .fl_dirty(fl_dirty), .fl_frame(fl_frame)
  );

  // reference model
  int mpage[SETS][WAYS];
  bit mv[SETS][WAYS], md[SETS][WAYS], mw[SETS][WAYS], mu[SETS][WAYS];
  int mfr[SETS][WAYS];
  int mptr[SETS];

  task automatic m_flush();
    for (int s = 0; s < SETS; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < WAYS; w++) mv[s][w] = 1'b0;
    end
  endtask

  task automatic m_fill(input logic [31:0] lin, input bit u, input bit wr,
                        input bit d, input int fr);
    int s, pg, way;
    s = int'(lin[29:28]);
    pg = int'(lin[31:12]);
    for (int w = 0; w < WAYS; w++)
      if (mv[s][w] && mpage[s][w] == pg && mu[s][w] == u && mw[s][w] == wr) begin
        md[s][w] = d; mfr[s][w] = fr; return;
      end
    way = -1;
    for (int w = 0; w < WAYS; w++)
      if (!mv[s][w] && way < 0) way = w;
    if (way < 0) way = mptr[s];
    mptr[s] = (mptr[s] + 1) % WAYS;
    mv[s][way] = 1'b1; mpage[s][way] = pg; mu[s][way] = u;
    mw[s][way] = wr; md[s][way] = d; mfr[s][way] = fr;
  endtask

  task automatic m_look(input bit req, input logic [31:0] lin, input bit u,
                        input bit wr, output bit h, output int fr);
    int s, pg;
    h = 1'b0; fr = 0;
    if (!req) return;
    s = int'(lin[29:28]);
    pg = int'(lin[31:12]);
    for (int w = 0; w < WAYS; w++)
      if (!h && mv[s][w] && mpage[s][w] == pg && mu[s][w] == u &&
          (!wr || (mw[s][w] && md[s][w]))) begin
        h = 1'b1; fr = mfr[s][w];
      end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: inputs applied now (after a falling edge), result checked
  // at the next falling edge against the model
  task automatic cyc(input string req, input bit f,
                     input bit fq, input logic [31:0] fa, input bit fu,
                     input bit fw, input bit fd, input int ff,
                     input bit lq, input logic [31:0] la, input bit lu, input bit lw);
    bit eh; int ef;
    flush = f; fl_req = fq; fl_lin = fa; fl_user = fu; fl_writable = fw;
    fl_dirty = fd; fl_frame = 20'(ff);
    lk_req = lq; lk_lin = la; lk_user = lu; lk_write = lw;
    if (f) m_flush();
    else if (fq) m_fill(fa, fu, fw, fd, ff);
    m_look(lq, la, lu, lw, eh, ef);
    @(posedge clk);
    @(negedge clk);
    check({req, " hit"}, int'(lk_hit), int'(eh));
    check({req, " frame"}, int'(lk_frame), ef);
  endtask

  task automatic fill(input string r, input logic [31:0] a, input bit u, input bit w,
                      input bit d, input int fr);
    cyc(r, 0, 1, a, u, w, d, fr, 0, '0, 0, 0);
  endtask

  task automatic look(input string r, input logic [31:0] a, input bit u, input bit w);
    cyc(r, 0, 0, '0, 0, 0, 0, 0, 1, a, u, w);
  endtask

  function automatic logic [31:0] mk(input int top, input int set, input int pool);
    return {2'(top), 2'(set), 8'h00, 8'(pool), 12'h0};
  endfunction

  initial begin
    #400000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    bit eh; int ef;
    m_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset hit", int'(lk_hit), 0);
    check("R9 reset frame", int'(lk_frame), 0);

    // R1 read hit on clean read-only entry
    fill("R5 first fill", mk(0, 0, 1), 0, 0, 0, 'h111);
    look("R1 read hit", mk(0, 0, 1), 0, 0);
    check("R1 explicit frame", int'(lk_frame), 'h111);
    // R2 user mismatch
    look("R2 user mismatch", mk(0, 0, 1), 1, 0);
    check("R2 explicit miss", int'(lk_hit), 0);
    // R3 write to clean read-only misses
    look("R3 write clean", mk(0, 0, 1), 0, 1);
    check("R3 explicit miss", int'(lk_hit), 0);
    // writable but clean: write still misses
    fill("R5 writable clean", mk(0, 0, 2), 0, 1, 0, 'h222);
    look("R3 write writable clean", mk(0, 0, 2), 0, 1);
    check("R3 explicit miss clean", int'(lk_hit), 0);
    // R4 dirty update in place, then write hits
    fill("R4 dirty update", mk(0, 0, 2), 0, 1, 1, 'h223);
    look("R3 write dirty hit", mk(0, 0, 2), 0, 1);
    check("R3 explicit hit", int'(lk_frame), 'h223);
    // read-only dirty still misses on write
    fill("R4 ro dirty", mk(0, 0, 1), 0, 0, 1, 'h112);
    look("R3 ro dirty write", mk(0, 0, 1), 0, 1);
    check("R3 explicit ro miss", int'(lk_hit), 0);
    // R10 two entries for one page differing in writable: lowest way wins
    fill("R10 second entry", mk(0, 0, 1), 0, 1, 1, 'h113);
    look("R10 read picks lowest", mk(0, 0, 1), 0, 0);
    check("R10 explicit frame", int'(lk_frame), 'h112);
    // R7 fill and lookup together
    cyc("R7 same cycle", 0, 1, mk(1, 0, 5), 1, 1, 1, 'h555, 1, mk(1, 0, 5), 1, 1);
    check("R7 explicit hit", int'(lk_hit), 1);
    // R9 no request
    cyc("R9 idle", 0, 0, '0, 0, 0, 0, 0, 0, mk(1, 0, 5), 1, 1);

    // R8 flush with same-cycle fill and lookup
    cyc("R8 flush", 1, 1, mk(0, 1, 9), 0, 0, 0, 'h999, 1, mk(0, 0, 2), 0, 0);
    check("R8 explicit miss", int'(lk_hit), 0);
    look("R8 dropped fill", mk(0, 1, 9), 0, 0);
    check("R8 explicit dropped", int'(lk_hit), 0);

    // R6 fill set 1 beyond capacity
    for (int i = 0; i < WAYS; i++) fill("R5 fill set", mk(0, 1, 16 + i), 0, 0, 0, 'h300 + i);
    fill("R4 update in full set", mk(0, 1, 19), 0, 0, 1, 'h3AA);
    fill("R6 evict oldest", mk(0, 1, 40), 0, 0, 0, 'h340);
    look("R6 oldest gone", mk(0, 1, 16), 0, 0);
    check("R6 explicit evicted", int'(lk_hit), 0);
    look("R6 second kept", mk(0, 1, 17), 0, 0);
    check("R6 explicit kept", int'(lk_hit), 1);
    fill("R6 evict next", mk(0, 1, 41), 0, 0, 0, 'h341);
    look("R6 second gone", mk(0, 1, 17), 0, 0);
    look("R4 updated kept", mk(0, 1, 19), 0, 0);
    check("R4 explicit frame", int'(lk_frame), 'h3AA);
    look("R5 other set untouched", mk(0, 2, 16), 0, 0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit f, fq, lq, fu, fw, fd, lu, lw;
      int fs, ls;
      f  = ($urandom % 250) == 0;
      fq = ($urandom % 10) < 4;
      lq = ($urandom % 10) < 8;
      fu = $urandom % 2; fw = $urandom % 2; fd = $urandom % 2;
      lu = $urandom % 2; lw = $urandom % 2;
      fs = $urandom % SETS;
      ls = (($urandom % 3) == 0) ? fs : int'($urandom % SETS);
      cyc("R1 R2 R3 R4 R6 R7 R10 random", f,
          fq, mk($urandom % 2, fs, $urandom % 6), fu, fw, fd, int'($urandom % 'h100000),
          lq, mk($urandom % 2, ls, $urandom % 6), lu, lw);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial void'($urandom(32'h1234_5678));
endmodule